// File: doc/BRIEF.md
# Sprite Attribute Page Copier

This block moves a 160-byte sprite attribute table out of ordinary memory into the sprite attribute RAM. The CPU starts a copy by writing one byte to a dedicated trigger register. That byte selects a 256-byte source page: the source for byte `n` is `{page, 8'h00} + n`. The destination for byte `n` is `16'hFE00 + n`. The written byte also stays in the trigger register and can be read on `page_q`.

Each byte goes through two phases. The read phase holds a request on the system bus until the bus returns valid data. The write phase spends one cycle presenting that byte to the attribute RAM. `busy` is high while a copy is running, and `done` pulses for one cycle after the final byte is written. A new trigger write while a copy is running discards the copy in progress and starts again from offset 0 with the new page.

Top module: `sprite_dma`

## Requirements
- R1: A cycle with `reg_wr` high and `reg_addr == 16'hFF46` is a trigger. The byte on `reg_wdata` appears on `page_q` from the next cycle, and `busy` is high from the next cycle.
- R2: A write to any other address has no effect: `page_q`, `busy`, `rd_req` and `wr_en` are unchanged.
- R3: Read requests cover the addresses `{page_q, 8'h00} + n` for n = 0 to 159, in increasing order.
- R4: Each write cycle presents `wr_addr = 16'hFE00 + n` and `wr_data` equal to the byte returned for source offset n.
- R5: A transfer that is not interrupted performs exactly 160 write cycles.
- R6: `rd_req` stays high with a stable `rd_addr` until `rd_valid` is high in a request cycle. The write for that byte comes in the following cycle, and `wr_en` is high only in that one cycle.
- R7: `busy` stays high through the cycle of the final write. In the next cycle `busy` is low and `done` is high for exactly one cycle.
- R8: A trigger while `busy` is high restarts the copy at offset 0 from the newly written page. No write for the abandoned page follows, and no `done` is produced for it.
- R9: Synchronous active-high `rst` clears `busy`, `done`, `rd_req`, `wr_en`, the offset and `page_q` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | CPU register write strobe |
| reg_addr | input | 16 | CPU register write address |
| reg_wdata | input | 8 | CPU register write data |
| page_q | output | 8 | Contents of the trigger register (source page) |
| rd_req | output | 1 | Source read request |
| rd_addr | output | 16 | Source read address |
| rd_valid | input | 1 | Source read data valid |
| rd_data | input | 8 | Source read data |
| wr_en | output | 1 | Attribute RAM write enable |
| wr_addr | output | 16 | Attribute RAM write address |
| wr_data | output | 8 | Attribute RAM write data |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle pulse after the final byte |

## Verification
The assertions take for granted that `rd_valid` only matters in cycles where `rd_req` is high. They also take for granted that the bus holds the data for the presented address during the accepting cycle. The bench's memory model never answers without an open request. It returns a fixed function of the requested address, after a latency of 0, 1 or 2 cycles. It drives triggers only through the register port. The retrigger and reset-abort cases are placed mid-copy, so that both fall in read and write phases of a live transfer.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int PAGE_W = ADDR_W - DATA_W;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_STORE = 2'd2
    } phase_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } store_beat_t;

    function automatic logic [ADDR_W-1:0] src_of(input logic [PAGE_W-1:0] page,
                                                 input logic [ADDR_W-1:0] off);
        return {page, {DATA_W{1'b0}}} + off;
    endfunction

    function automatic logic [ADDR_W-1:0] dst_of(input logic [ADDR_W-1:0] base,
                                                 input logic [ADDR_W-1:0] off);
        return base + off;
    endfunction

endpackage

// File: rtl/sprite_dma_trig.sv
module sprite_dma_trig
    import sprite_dma_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hFF46
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              start,
    output logic [PAGE_W-1:0] page
);

    assign start = reg_wr && (reg_addr == TRIG_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            page <= '0;
        end else if (start) begin
            page <= reg_wdata;
        end
    end

    AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(page)); // R2

endmodule

// File: rtl/sprite_dma_seq.sv
module sprite_dma_seq
    import sprite_dma_pkg::*;
#(
    parameter int LEN   = 160,
    parameter int OFF_W = $clog2(LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output phase_t            phase,
    output logic [OFF_W-1:0]  offset,
    output logic [DATA_W-1:0] held,
    output logic              done
);

    localparam logic [OFF_W-1:0] LAST = OFF_W'(LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            offset <= '0;
            held   <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                phase  <= PH_FETCH;
                offset <= '0;
            end else begin
                case (phase)
                    PH_FETCH: begin
                        if (rd_valid) begin
                            held  <= rd_data;
                            phase <= PH_STORE;
                        end
                    end
                    PH_STORE: begin
                        if (offset == LAST) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            offset <= offset + 1'b1;
                            phase  <= PH_FETCH;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    AST_OFFSET_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        offset <= LAST); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_DONE_AFTER_STORE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(phase == PH_STORE && offset == LAST)); // R7

endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
    import sprite_dma_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hFF46,
    parameter logic [ADDR_W-1:0] DEST_BASE = 16'hFE00,
    parameter int                TABLE_LEN = 160
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [PAGE_W-1:0] page_q,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done
);

    localparam int OFF_W = $clog2(TABLE_LEN);

    logic              start;
    phase_t            phase;
    logic [OFF_W-1:0]  offset;
    logic [DATA_W-1:0] held;
    store_beat_t       beat;

    sprite_dma_trig #(
        .TRIG_ADDR (TRIG_ADDR)
    ) u_trig (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .start     (start),
        .page      (page_q)
    );

    sprite_dma_seq #(
        .LEN   (TABLE_LEN),
        .OFF_W (OFF_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .phase    (phase),
        .offset   (offset),
        .held     (held),
        .done     (done)
    );

    always_comb begin
        beat.en   = (phase == PH_STORE);
        beat.addr = dst_of(DEST_BASE, ADDR_W'(offset));
        beat.data = held;
    end

    assign rd_req  = (phase == PH_FETCH);
    assign rd_addr = src_of(page_q, ADDR_W'(offset));
    assign wr_en   = beat.en;
    assign wr_addr = beat.addr;
    assign wr_data = beat.data;
    assign busy    = (phase != PH_IDLE);

    AST_TRIGGER_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |=> busy && rd_req && (rd_addr == {page_q, 8'h00})); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_valid && !start |=> rd_req && $stable(rd_addr)); // R6

    AST_STORE_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(rd_req && rd_valid && !start)); // R6

    AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_en && !start |=> !wr_en); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !rd_req && !wr_en); // R7

endmodule

// File: tb/sprite_dma_test.sv
module sprite_dma_test;

    localparam int LEN = 160;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  page_q;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_data = '0;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic        busy;
    logic        done;

    sprite_dma uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .page_q(page_q), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done)
    );

    always #2.5 clk = ~clk;

    int vectors = 0;
    int errors  = 0;
    bit finished = 1'b0;

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // memory model: answers after 'lat' request cycles
    int lat = 0;
    int waited = 0;
    always @(negedge clk) begin
        #1;
        if (rd_req && waited >= lat) begin
            rd_valid = 1'b1;
            rd_data  = mem_f(rd_addr);
            waited   = 0;
        end else begin
            rd_valid = 1'b0;
            waited   = rd_req ? waited + 1 : 0;
        end
    end

    // reference model: queue of pending source addresses
    int   exp_src[$];
    logic [7:0] exp_page = '0;
    bit   last_pop = 1'b0;
    int   wr_count = 0;
    int   done_count = 0;

    always @(negedge clk) begin
        bit trig;
        bit exp_done;
        bit exp_busy;
        if (rst) begin
            exp_src.delete();
            exp_page = '0;
            last_pop = 1'b0;
            wr_count = 0;
        end else begin
            trig = reg_wr && (reg_addr == 16'hFF46);
            exp_done = last_pop && !trig;
            last_pop = 1'b0;
            if (trig) begin
                exp_src.delete();
                exp_page = reg_wdata;
                wr_count = 0;
                for (int n = 0; n < LEN; n++) exp_src.push_back({reg_wdata, 8'h00} + n);
            end
            exp_busy = (exp_src.size() != 0);
            chk(page_q == exp_page, "R1/R2 page", page_q, exp_page);
            chk(busy == exp_busy, "R7 busy", busy, exp_busy);
            chk(done == exp_done, "R7 done", done, exp_done);
            if (done) done_count++;
            if (rd_req) begin
                if (exp_src.size() == 0) chk(1'b0, "R3 stray read", rd_addr, 0);
                else chk(rd_addr == exp_src[0][15:0], "R3 read addr", rd_addr, exp_src[0]);
            end
            if (wr_en) begin
                if (exp_src.size() == 0) begin
                    chk(1'b0, "R8 stray write", wr_addr, 0);
                end else begin
                    chk(wr_addr == 16'hFE00 + 16'(LEN - exp_src.size()), "R4 write addr",
                        wr_addr, 16'hFE00 + LEN - exp_src.size());
                    chk(wr_data == mem_f(exp_src[0][15:0]), "R4 write data",
                        wr_data, mem_f(exp_src[0][15:0]));
                    void'(exp_src.pop_front());
                    wr_count++;
                    if (exp_src.size() == 0) begin
                        last_pop = 1'b1;
                        chk(wr_count == LEN, "R5 byte count", wr_count, LEN);
                    end
                end
            end
        end
    end

    task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (busy && guard < 5000);
        #2;
    endtask

    initial begin
        int dc;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #2;
        // R9 reset state
        chk(!busy && !done && !rd_req && !wr_en && page_q == 8'h00, "R9 reset state",
            {busy, done, rd_req, wr_en}, 0);

        // R2: non-trigger write ignored
        reg_write(16'hFF47, 8'h55);
        repeat (3) @(negedge clk); #2;
        chk(!busy && !rd_req && !wr_en && page_q == 8'h00, "R2 other address",
            {busy, page_q}, 0);

        // R1 R3 R4 R5 R6 with latency 0
        lat = 0;
        reg_write(16'hFF46, 8'hC1);
        wait_idle();
        // R6 with latency 2, page 0x00
        lat = 2;
        reg_write(16'hFF46, 8'h00);
        wait_idle();
        // page 0xFF boundary, latency 1
        lat = 1;
        reg_write(16'hFF46, 8'hFF);
        wait_idle();
        chk(done_count == 3, "R7 done pulses", done_count, 3);

        // R8: restart mid-copy
        dc = done_count;
        reg_write(16'hFF46, 8'h80);
        while (wr_count < 50) @(negedge clk);
        #1;
        reg_wr = 1'b1; reg_addr = 16'hFF46; reg_wdata = 8'h3A;
        @(negedge clk); #1;
        reg_wr = 1'b0;
        wait_idle();
        chk(done_count == dc + 1, "R8 single done after restart", done_count, dc + 1);
        chk(page_q == 8'h3A, "R8 new page kept", page_q, 8'h3A);

        // R9: reset mid-copy
        reg_write(16'hFF46, 8'h12);
        repeat (20) @(negedge clk);
        #1 rst = 1'b1;
        @(negedge clk); #1 rst = 1'b0;
        #1;
        chk(!busy && !rd_req && !wr_en && page_q == 8'h00, "R9 reset abort",
            {busy, rd_req, wr_en, page_q}, 0);
        repeat (5) @(negedge clk); #2;
        chk(!busy && !wr_en && !done, "R9 stays idle", {busy, wr_en, done}, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule